// File: doc/BRIEF.md
# Speculation Tag Register File

This block is the architectural register file for a core that hoists loads above the branches guarding them. It has an integer bank and a floating-point bank. A hoisted load may hit a fault. When it does, no trap is raised at that point. The destination register is marked as holding a deferred fault instead. An integer register carries one poison bit beside its data. A floating-point register has no extra bit: it stores one reserved value pattern, and that value is the mark.

Ordinary operations pass the mark along. When the pipeline writes a result whose source operand was poisoned, the destination becomes poisoned too, and the operation's own fault is dropped. Only loads can create a new mark. A later explicit check operation tests one register and answers one cycle later. The answer is a completion pulse and, if the register is marked, a recovery-redirect pulse. The pipeline then jumps to recovery code.

The file has two read ports, one result write port and one load-result port. Reads are combinational and see same-cycle writes, poison included. The pipeline, the memory system and the recovery code are outside this block.

Top module: `stf_regfile`

## Requirements
- R1: After reset every register in both banks reads as value 0 with poison 0, and `chk_done` and `chk_redirect` are 0.
- R2: A result write (`wr_en`) with `wr_src_poison`=0 to an integer register stores `wr_val` and clears that register's poison bit. Both read ports return it from the next cycle on.
- R3: A load with `ld_spec`=1 and `ld_fault`=1 to an integer register stores value 0 with poison 1. If either `ld_spec` or `ld_fault` is 0, the load stores `ld_val` with poison 0, so the fault flag has no effect on non-speculative loads.
- R4: A speculative faulting load to a floating-point register stores the reserved pattern POISON (default 32'h7FA5_A5A5). The register then reads with poison 1. A floating-point register reads poison 1 exactly when its value equals POISON.
- R5: A result write with `wr_src_poison`=1 makes its destination poisoned, whatever `wr_val` holds. An integer destination reads value 0 with poison 1. A floating-point destination reads POISON.
- R6: A non-poisoned write of the value POISON to a floating-point register is discarded, through either the result port or the load port. The register keeps its previous contents. Integer registers accept that value as ordinary data.
- R7: A read port addressing a register that is written in the same cycle returns the newly written value and poison rather than the stored ones.
- R8: When the load port and the result port write the same register in the same cycle, the load's effective write wins. A write discarded under R6 does not count. Writes to different registers both take effect.
- R9: One cycle after `chk_req`, `chk_done` is 1 for exactly one cycle. `chk_redirect` is 1 in that same cycle only if the tested register was poisoned, counting a write in the request cycle. Without a request both stay 0.
- R10: A check changes no register: the tested register keeps its value and poison afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_is_fp | input | 1 | Read port 0 bank select (1 = floating-point) |
| rd0_idx | input | AW | Read port 0 register index |
| rd0_val | output | DW | Read port 0 value |
| rd0_poison | output | 1 | Read port 0 deferred-fault mark |
| rd1_is_fp | input | 1 | Read port 1 bank select |
| rd1_idx | input | AW | Read port 1 register index |
| rd1_val | output | DW | Read port 1 value |
| rd1_poison | output | 1 | Read port 1 deferred-fault mark |
| wr_en | input | 1 | Result write enable |
| wr_is_fp | input | 1 | Result write bank select |
| wr_idx | input | AW | Result write index |
| wr_val | input | DW | Result write value |
| wr_src_poison | input | 1 | A source operand of this result was poisoned |
| ld_en | input | 1 | Load result enable |
| ld_is_fp | input | 1 | Load result bank select |
| ld_idx | input | AW | Load destination index |
| ld_val | input | DW | Load data |
| ld_spec | input | 1 | Load is the control-speculative form |
| ld_fault | input | 1 | Load raised a fault |
| chk_req | input | 1 | Check request |
| chk_is_fp | input | 1 | Check bank select |
| chk_idx | input | AW | Register to test |
| chk_done | output | 1 | Check response valid (one cycle) |
| chk_redirect | output | 1 | Tested register was poisoned: branch to recovery |

## Verification
The bench goes after the meeting points of the two marking schemes.

- **Discarding the reserved value.** An untagged write of the reserved value to a floating-point register must be dropped. A design that stored it would create a mark with no fault behind it. A design that applied the rule to integers would lose legal data.
- **Port collisions.** When load and result writes hit the same register, a wrong precedence would leave the stale result in place. A read of a register written that cycle is a related case: a bypass that forwards the value but not the poison would let an untagged read escape a pending fault.
- **Check timing and side effects.** A check must answer exactly one cycle late and must leave the mark intact. An off-by-one response, or a check that clears the poison, breaks the recovery sequence.

// File: rtl/stf_pkg.sv
package stf_pkg;
    localparam int          DEF_NREG   = 16;
    localparam int          DEF_DW     = 32;
    localparam logic [31:0] DEF_POISON = 32'h7FA5_A5A5;
    localparam int          RD_PORTS   = 3; // two architectural reads plus the check lookup
endpackage

// File: rtl/stf_write_lane.sv
// Shapes one write source for one bank: bank match, poison shaping and
// suppression of an untagged reserved value in the floating-point bank.
module stf_write_lane #(
    parameter int          DW     = 32,
    parameter int          AW     = 4,
    parameter bit          IS_FP  = 1'b0,
    parameter logic [DW-1:0] POISON = '1
) (
    input  logic          src_en,
    input  logic          src_is_fp,
    input  logic [AW-1:0] src_idx,
    input  logic [DW-1:0] src_val,
    input  logic          src_tag,
    output logic          lane_en,
    output logic [AW-1:0] lane_idx,
    output logic [DW-1:0] lane_val,
    output logic          lane_tag
);
    logic bank_hit;
    assign bank_hit = src_en && (src_is_fp == IS_FP);
    assign lane_idx = src_idx;
    assign lane_tag = src_tag;

    generate
        if (IS_FP) begin : g_fp
            assign lane_val = src_tag ? POISON : src_val;
            assign lane_en  = bank_hit && (src_tag || (src_val != POISON));
        end else begin : g_int
            assign lane_val = src_tag ? '0 : src_val;
            assign lane_en  = bank_hit;
        end
    endgenerate
endmodule

// File: rtl/stf_read_port.sv
// One bank lookup with same-cycle forwarding; lane b has priority over lane a.
module stf_read_port #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int AW   = 4
) (
    input  logic [NREG-1:0][DW-1:0] bank_vals,
    input  logic [NREG-1:0]         bank_tags,
    input  logic [AW-1:0]           idx,
    input  logic                    a_en,
    input  logic [AW-1:0]           a_idx,
    input  logic [DW-1:0]           a_val,
    input  logic                    a_tag,
    input  logic                    b_en,
    input  logic [AW-1:0]           b_idx,
    input  logic [DW-1:0]           b_val,
    input  logic                    b_tag,
    output logic [DW-1:0]           val,
    output logic                    tag
);
    always_comb begin
        val = bank_vals[idx];
        tag = bank_tags[idx];
        if (a_en && (a_idx == idx)) begin
            val = a_val;
            tag = a_tag;
        end
        if (b_en && (b_idx == idx)) begin
            val = b_val;
            tag = b_tag;
        end
    end
endmodule

// File: rtl/stf_regfile.sv
module stf_regfile
    import stf_pkg::*;
#(
    parameter int            NREG   = DEF_NREG,
    parameter int            DW     = DEF_DW,
    parameter logic [DW-1:0] POISON = DEF_POISON[DW-1:0],
    localparam int           AW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd0_is_fp,
    input  logic [AW-1:0] rd0_idx,
    output logic [DW-1:0] rd0_val,
    output logic          rd0_poison,
    input  logic          rd1_is_fp,
    input  logic [AW-1:0] rd1_idx,
    output logic [DW-1:0] rd1_val,
    output logic          rd1_poison,
    input  logic          wr_en,
    input  logic          wr_is_fp,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic          wr_src_poison,
    input  logic          ld_en,
    input  logic          ld_is_fp,
    input  logic [AW-1:0] ld_idx,
    input  logic [DW-1:0] ld_val,
    input  logic          ld_spec,
    input  logic          ld_fault,
    input  logic          chk_req,
    input  logic          chk_is_fp,
    input  logic [AW-1:0] chk_idx,
    output logic          chk_done,
    output logic          chk_redirect
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] ivals;
        logic [NREG-1:0]         itags;
        logic [NREG-1:0][DW-1:0] fvals;
        logic                    done;
        logic                    redirect;
    } state_t;

    state_t st_d, st_q;

    // Write lanes: index 0 = result port, 1 = load port; per bank.
    logic          ld_tag;
    logic          il_en  [2];
    logic [AW-1:0] il_idx [2];
    logic [DW-1:0] il_val [2];
    logic          il_tag [2];
    logic          fl_en  [2];
    logic [AW-1:0] fl_idx [2];
    logic [DW-1:0] fl_val [2];
    logic          fl_tag [2];

    assign ld_tag = ld_spec && ld_fault;

    logic          src_en  [2];
    logic          src_fp  [2];
    logic [AW-1:0] src_idx [2];
    logic [DW-1:0] src_val [2];
    logic          src_tag [2];

    assign src_en[0]  = wr_en;    assign src_en[1]  = ld_en;
    assign src_fp[0]  = wr_is_fp; assign src_fp[1]  = ld_is_fp;
    assign src_idx[0] = wr_idx;   assign src_idx[1] = ld_idx;
    assign src_val[0] = wr_val;   assign src_val[1] = ld_val;
    assign src_tag[0] = wr_src_poison; assign src_tag[1] = ld_tag;

    generate
        for (genvar s = 0; s < 2; s++) begin : g_src
            stf_write_lane #(.DW(DW), .AW(AW), .IS_FP(1'b0), .POISON(POISON)) u_int_lane (
                .src_en(src_en[s]), .src_is_fp(src_fp[s]), .src_idx(src_idx[s]),
                .src_val(src_val[s]), .src_tag(src_tag[s]),
                .lane_en(il_en[s]), .lane_idx(il_idx[s]), .lane_val(il_val[s]), .lane_tag(il_tag[s]));
            stf_write_lane #(.DW(DW), .AW(AW), .IS_FP(1'b1), .POISON(POISON)) u_fp_lane (
                .src_en(src_en[s]), .src_is_fp(src_fp[s]), .src_idx(src_idx[s]),
                .src_val(src_val[s]), .src_tag(src_tag[s]),
                .lane_en(fl_en[s]), .lane_idx(fl_idx[s]), .lane_val(fl_val[s]), .lane_tag(fl_tag[s]));
        end
    endgenerate

    // Floating-point poison is derived from the stored value, not stored.
    logic [NREG-1:0] fp_marks;
    generate
        for (genvar r = 0; r < NREG; r++) begin : g_fmark
            assign fp_marks[r] = (st_q.fvals[r] == POISON);
        end
    endgenerate

    // Lookups: 0 and 1 are the read ports, 2 serves the check.
    logic          lk_fp   [RD_PORTS];
    logic [AW-1:0] lk_idx  [RD_PORTS];
    logic [DW-1:0] lk_ival [RD_PORTS];
    logic          lk_itag [RD_PORTS];
    logic [DW-1:0] lk_fval [RD_PORTS];
    logic          lk_ftag [RD_PORTS];
    logic [DW-1:0] lk_val  [RD_PORTS];
    logic          lk_tag  [RD_PORTS];

    assign lk_fp[0] = rd0_is_fp; assign lk_idx[0] = rd0_idx;
    assign lk_fp[1] = rd1_is_fp; assign lk_idx[1] = rd1_idx;
    assign lk_fp[2] = chk_is_fp; assign lk_idx[2] = chk_idx;

    generate
        for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
            stf_read_port #(.NREG(NREG), .DW(DW), .AW(AW)) u_int_rd (
                .bank_vals(st_q.ivals), .bank_tags(st_q.itags), .idx(lk_idx[p]),
                .a_en(il_en[0]), .a_idx(il_idx[0]), .a_val(il_val[0]), .a_tag(il_tag[0]),
                .b_en(il_en[1]), .b_idx(il_idx[1]), .b_val(il_val[1]), .b_tag(il_tag[1]),
                .val(lk_ival[p]), .tag(lk_itag[p]));
            stf_read_port #(.NREG(NREG), .DW(DW), .AW(AW)) u_fp_rd (
                .bank_vals(st_q.fvals), .bank_tags(fp_marks), .idx(lk_idx[p]),
                .a_en(fl_en[0]), .a_idx(fl_idx[0]), .a_val(fl_val[0]), .a_tag(fl_tag[0]),
                .b_en(fl_en[1]), .b_idx(fl_idx[1]), .b_val(fl_val[1]), .b_tag(fl_tag[1]),
                .val(lk_fval[p]), .tag(lk_ftag[p]));
            assign lk_val[p] = lk_fp[p] ? lk_fval[p] : lk_ival[p];
            assign lk_tag[p] = lk_fp[p] ? lk_ftag[p] : lk_itag[p];
        end
    endgenerate

    assign rd0_val      = lk_val[0];
    assign rd0_poison   = lk_tag[0];
    assign rd1_val      = lk_val[1];
    assign rd1_poison   = lk_tag[1];
    assign chk_done     = st_q.done;
    assign chk_redirect = st_q.redirect;

    always_comb begin
        st_d = st_q;
        // Later lane (load) overrides the result lane on the same register.
        for (int s = 0; s < 2; s++) begin
            if (il_en[s]) begin
                st_d.ivals[il_idx[s]] = il_val[s];
                st_d.itags[il_idx[s]] = il_tag[s];
            end
            if (fl_en[s]) begin
                st_d.fvals[fl_idx[s]] = fl_val[s];
            end
        end
        st_d.done     = chk_req;
        st_d.redirect = chk_req && lk_tag[2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stf_regfile_chk.sv
module stf_regfile_chk #(
    parameter int            NREG   = 16,
    parameter int            DW     = 32,
    parameter logic [DW-1:0] POISON = '1,
    localparam int           AW     = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd0_is_fp,
    input logic [AW-1:0] rd0_idx,
    input logic [DW-1:0] rd0_val,
    input logic          rd0_poison,
    input logic          rd1_is_fp,
    input logic [AW-1:0] rd1_idx,
    input logic          rd1_poison,
    input logic          wr_en,
    input logic          wr_is_fp,
    input logic [AW-1:0] wr_idx,
    input logic [DW-1:0] wr_val,
    input logic          wr_src_poison,
    input logic          ld_en,
    input logic          ld_is_fp,
    input logic [AW-1:0] ld_idx,
    input logic [DW-1:0] ld_val,
    input logic          ld_spec,
    input logic          ld_fault,
    input logic          chk_req,
    input logic          chk_done,
    input logic          chk_redirect
);
    assert_check_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> chk_done);

    assert_no_idle_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> !chk_done);

    assert_redirect_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_redirect |-> chk_done);

    assert_int_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_is_fp && !wr_src_poison && !ld_en && !rd0_is_fp && rd0_idx == wr_idx)
        |-> (rd0_val == wr_val && !rd0_poison));

    assert_fault_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_spec && ld_fault && rd1_is_fp == ld_is_fp && rd1_idx == ld_idx)
        |-> rd1_poison);

    assert_load_beats_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && wr_en && !ld_spec && ld_is_fp == wr_is_fp && ld_idx == wr_idx
         && !(ld_is_fp && ld_val == POISON) && rd0_is_fp == ld_is_fp && rd0_idx == ld_idx)
        |-> (rd0_val == ld_val && !rd0_poison));
endmodule

bind stf_regfile stf_regfile_chk #(.NREG(NREG), .DW(DW), .POISON(POISON)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_is_fp(rd0_is_fp), .rd0_idx(rd0_idx), .rd0_val(rd0_val), .rd0_poison(rd0_poison),
    .rd1_is_fp(rd1_is_fp), .rd1_idx(rd1_idx), .rd1_poison(rd1_poison),
    .wr_en(wr_en), .wr_is_fp(wr_is_fp), .wr_idx(wr_idx), .wr_val(wr_val),
    .wr_src_poison(wr_src_poison),
    .ld_en(ld_en), .ld_is_fp(ld_is_fp), .ld_idx(ld_idx), .ld_val(ld_val),
    .ld_spec(ld_spec), .ld_fault(ld_fault),
    .chk_req(chk_req), .chk_done(chk_done), .chk_redirect(chk_redirect));

// File: tb/stf_regfile_tb.sv
`timescale 1ns/1ps
module stf_regfile_tb_top;
    localparam int          NREG = 16;
    localparam int          DW   = 32;
    localparam int          AW   = 4;
    localparam logic [31:0] PAT  = 32'h7FA5_A5A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          rd0_is_fp = 0, rd1_is_fp = 0;
    logic [AW-1:0] rd0_idx = 0, rd1_idx = 0;
    logic [DW-1:0] rd0_val, rd1_val;
    logic          rd0_poison, rd1_poison;
    logic          wr_en = 0, wr_is_fp = 0, wr_src_poison = 0;
    logic [AW-1:0] wr_idx = 0;
    logic [DW-1:0] wr_val = 0;
    logic          ld_en = 0, ld_is_fp = 0, ld_spec = 0, ld_fault = 0;
    logic [AW-1:0] ld_idx = 0;
    logic [DW-1:0] ld_val = 0;
    logic          chk_req = 0, chk_is_fp = 0;
    logic [AW-1:0] chk_idx = 0;
    logic          chk_done, chk_redirect;

    stf_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd0_is_fp(rd0_is_fp), .rd0_idx(rd0_idx), .rd0_val(rd0_val), .rd0_poison(rd0_poison),
        .rd1_is_fp(rd1_is_fp), .rd1_idx(rd1_idx), .rd1_val(rd1_val), .rd1_poison(rd1_poison),
        .wr_en(wr_en), .wr_is_fp(wr_is_fp), .wr_idx(wr_idx), .wr_val(wr_val),
        .wr_src_poison(wr_src_poison),
        .ld_en(ld_en), .ld_is_fp(ld_is_fp), .ld_idx(ld_idx), .ld_val(ld_val),
        .ld_spec(ld_spec), .ld_fault(ld_fault),
        .chk_req(chk_req), .chk_is_fp(chk_is_fp), .chk_idx(chk_idx),
        .chk_done(chk_done), .chk_redirect(chk_redirect));

    // Behavioural model
    logic [31:0] m_int [NREG];
    bit          m_itg [NREG];
    logic [31:0] m_fp  [NREG];
    bit          exp_done = 0, exp_redir = 0;
    int          n_checks = 0, n_errors = 0;
    bit          finished = 0;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_write(inout logic [31:0] iv [NREG], inout bit it [NREG],
                                        inout logic [31:0] fv [NREG], input bit is_fp,
                                        input logic [AW-1:0] idx, input logic [31:0] val, input bit tag);
        if (!is_fp) begin
            iv[idx] = tag ? 32'h0 : val;
            it[idx] = tag;
        end else if (tag) begin
            fv[idx] = PAT;
        end else if (val != PAT) begin
            fv[idx] = val;
        end
    endfunction

    // Compare outputs for the current cycle, then advance the model one edge.
    task automatic step(string req);
        logic [31:0] ni [NREG];
        bit          nt [NREG];
        logic [31:0] nf [NREG];
        logic [31:0] e0, e1;
        bit          t0, t1, tc;
        #1;
        ni = m_int; nt = m_itg; nf = m_fp;
        if (wr_en) model_write(ni, nt, nf, wr_is_fp, wr_idx, wr_val, wr_src_poison);
        if (ld_en) model_write(ni, nt, nf, ld_is_fp, ld_idx, ld_val, ld_spec && ld_fault);
        e0 = rd0_is_fp ? nf[rd0_idx] : ni[rd0_idx];
        t0 = rd0_is_fp ? (nf[rd0_idx] == PAT) : nt[rd0_idx];
        e1 = rd1_is_fp ? nf[rd1_idx] : ni[rd1_idx];
        t1 = rd1_is_fp ? (nf[rd1_idx] == PAT) : nt[rd1_idx];
        tc = chk_is_fp ? (nf[chk_idx] == PAT) : nt[chk_idx];
        check(rd0_val === e0 && rd0_poison === t0, req, "rd0 {poison,val}",
              {rd0_poison, rd0_val[30:0]}, {t0, e0[30:0]});
        check(rd1_val === e1 && rd1_poison === t1, req, "rd1 {poison,val}",
              {rd1_poison, rd1_val[30:0]}, {t1, e1[30:0]});
        check(chk_done === exp_done && chk_redirect === exp_redir, req, "check {done,redirect}",
              {30'h0, chk_done, chk_redirect}, {30'h0, exp_done, exp_redir});
        exp_done  = chk_req;
        exp_redir = chk_req && tc;
        m_int = ni; m_itg = nt; m_fp = nf;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; ld_en = 0; chk_req = 0; wr_src_poison = 0; ld_spec = 0; ld_fault = 0;
    endtask

    task automatic rd(bit f0, int i0, bit f1, int i1);
        rd0_is_fp = f0; rd0_idx = AW'(i0); rd1_is_fp = f1; rd1_idx = AW'(i1);
    endtask

    task automatic wr(bit f, int i, logic [31:0] v, bit t);
        wr_en = 1; wr_is_fp = f; wr_idx = AW'(i); wr_val = v; wr_src_poison = t;
    endtask

    task automatic ld(bit f, int i, logic [31:0] v, bit s, bit flt);
        ld_en = 1; ld_is_fp = f; ld_idx = AW'(i); ld_val = v; ld_spec = s; ld_fault = flt;
    endtask

    task automatic ck(bit f, int i);
        chk_req = 1; chk_is_fp = f; chk_idx = AW'(i);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin m_int[i] = 0; m_itg[i] = 0; m_fp[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents of both banks and idle check outputs
        for (int i = 0; i < NREG; i++) begin rd(0, i, 1, i); step("R1"); end

        // R2: plain integer write then read on both ports
        wr(0, 3, 32'h0000_1234, 0); rd(0, 0, 0, 1); step("R2");
        idle(); rd(0, 3, 0, 3); step("R2");

        // R3: speculative faulting load poisons; other load forms ignore the fault flag
        ld(0, 5, 32'hDEAD_BEEF, 1, 1); rd(0, 0, 0, 1); step("R3");
        ld(0, 6, 32'h0000_0066, 0, 1); step("R3");
        ld(0, 7, 32'h0000_0077, 1, 0); step("R3");
        idle(); rd(0, 5, 0, 6); step("R3");
        rd(0, 7, 0, 5); step("R3");

        // R4: floating-point poison is the reserved value
        ld(1, 2, 32'h3F80_0000, 1, 1); step("R4");
        idle(); rd(1, 2, 1, 3); step("R4");

        // R5: poison propagation through result writes
        wr(0, 3, 32'h5555_5555, 1); step("R5");
        wr(1, 4, 32'h4000_0000, 1); step("R5");
        idle(); rd(0, 3, 1, 4); step("R5");

        // R6: untagged reserved value is dropped in the fp bank only
        wr(1, 5, 32'h3F80_0000, 0); step("R6");
        wr(1, 5, PAT, 0); step("R6");
        idle(); ld(1, 5, PAT, 0, 0); step("R6");
        idle(); wr(0, 8, PAT, 0); rd(1, 5, 0, 8); step("R6");
        idle(); rd(1, 5, 0, 8); step("R6");

        // R7: same-cycle forwarding, including poison
        wr(0, 9, 32'hCAFE_0009, 0); rd(0, 9, 0, 9); step("R7");
        idle(); ld(1, 9, 32'h0, 1, 1); rd(1, 9, 0, 9); step("R7");
        idle(); rd(1, 9, 0, 9); step("R7");

        // R8: load wins on the same register; discarded load does not
        wr(0, 10, 32'hAAAA_0000, 0); ld(0, 10, 32'hBBBB_0000, 0, 0); rd(0, 10, 0, 11); step("R8");
        wr(0, 11, 32'h1111_1111, 0); ld(0, 12, 32'h2222_2222, 0, 0); rd(0, 11, 0, 12); step("R8");
        wr(1, 6, 32'h4040_0000, 0); ld(1, 6, PAT, 0, 0); rd(1, 6, 0, 10); step("R8");
        idle(); rd(1, 6, 0, 12); step("R8");

        // R9: check responses for poisoned and clean registers
        ck(0, 5); step("R9");
        ck(0, 7); step("R9");
        ck(1, 2); step("R9");
        idle(); step("R9");
        ld(0, 13, 32'h0, 1, 1); ck(0, 13); step("R9");
        idle(); step("R9");

        // R10: a check leaves the register untouched
        ck(0, 5); rd(0, 5, 1, 2); step("R10");
        ck(1, 2); rd(0, 5, 1, 2); step("R10");
        idle(); rd(0, 5, 1, 2); step("R10");

        // Mixed traffic, all rules at once (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < 4000; n++) begin
            wr_en = $urandom_range(0, 1); wr_is_fp = $urandom_range(0, 1);
            wr_idx = AW'($urandom_range(0, 7)); wr_src_poison = ($urandom_range(0, 5) == 0);
            wr_val = ($urandom_range(0, 4) == 0) ? PAT : $urandom;
            ld_en = $urandom_range(0, 1); ld_is_fp = $urandom_range(0, 1);
            ld_idx = AW'($urandom_range(0, 7)); ld_spec = $urandom_range(0, 1);
            ld_fault = $urandom_range(0, 1);
            ld_val = ($urandom_range(0, 4) == 0) ? PAT : $urandom;
            chk_req = $urandom_range(0, 1); chk_is_fp = $urandom_range(0, 1);
            chk_idx = AW'($urandom_range(0, 7));
            rd(1'($urandom_range(0, 1)), $urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom_range(0, 7));
            step("R7");
        end
        idle(); step("R9");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule